// File: doc/BRIEF.md
# Two-Way Instruction Cache with Victim Buffer

This block is a small read-only instruction cache for a processor whose words and addresses are both 32 bits wide and whose addresses count words. The main array holds eight words as four two-word lines, arranged as two sets of two ways. Each set replaces its least recently used way. Beside the array sits a fully associative victim buffer of two lines. The buffer catches every valid line that a fill pushes out of the array. When the array misses but the buffer hits, the buffer's line and the array's replacement line trade places.

The fetch side presents one word address at a time with a valid/ready handshake. One cycle after the request is accepted, or one cycle after the line arrives on a miss, the block returns the word together with two separate flags: one for an array hit and one for a victim-buffer hit. A miss in both places asks the next level for the whole line at a line-aligned address and waits for it. The cache never takes stores.

Top module: `icache_victim`

## Requirements
- R1: While reset is high and right after it is released, no line is valid in the array or the buffer, so the first access to any address misses in both. reqReady is 1, and fillReq and respValid are 0.
- R2: Address bit 0 selects the word within a line and bit 1 selects the set. Bits 31..2 are the tag. fillAddr is the requested address with bit 0 cleared.
- R3: On a miss in both the array and the buffer, fillReq rises in the cycle after acceptance and stays high until fillValid is sampled. In the cycle after that, respValid is 1, both hit flags are 0, and respData is the word of fillData chosen by address bit 0. Word 0 is fillData[31:0] and word 1 is fillData[63:32].
- R4: An array hit gives respValid=1, respMainHit=1, respVictimHit=0 and the stored word in the cycle after acceptance.
- R5: A fill or swap writes the lowest-numbered invalid way of its set. If both ways are valid, it writes the least recently used way. Any hit, fill or swap makes the way it touched the most recently used way of the set.
- R6: A valid line pushed out of the array by a fill goes into the lowest invalid buffer slot, or into the slot named by the replacement pointer when both slots are valid. Every write into slot k moves the pointer to slot (k+1) mod 2.
- R7: On an array miss with a buffer hit, the response comes in the cycle after acceptance with respMainHit=0, respVictimHit=1 and the buffered word. The buffered line moves into the array, and the line it replaces moves into the freed slot.
- R8: A line is never valid in the array and in the buffer at the same time.
- R9: reqReady is 0 while a fill is pending. A reqValid presented then is ignored and produces no response.
- R10: A fillValid pulse while no fill is pending is ignored. It causes no response and does not change the contents of the array or the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Fetch request present |
| reqAddr | input | 32 | Word address of the fetch |
| reqReady | output | 1 | Block can take a request this cycle |
| respValid | output | 1 | Response word valid |
| respData | output | 32 | Fetched word |
| respMainHit | output | 1 | Response was served by the main array |
| respVictimHit | output | 1 | Response was served by the victim buffer |
| fillReq | output | 1 | Line request to the next level |
| fillAddr | output | 32 | Line-aligned address of the requested line |
| fillValid | input | 1 | Next level returns the line this cycle |
| fillData | input | 64 | Returned line, word 0 in the low half |

## Verification
The assertions assume that the next level returns a line only while fillReq is high. They also assume that the fetch side holds no request open across a response it has not consumed. The only exceptions are the deliberate stray pulses used to test R9 and R10. The stimulus presents one request at a time, answers each fillReq one cycle later, and confines stray pulses to directed cases. The random addresses come from a pool of twelve lines split across both sets. That pool keeps both sets full and cycles lines through the victim buffer, so array hits, buffer swaps and evictions all occur repeatedly.

// File: rtl/icache_pkg.sv
package icache_pkg;
  localparam int WAYS = 2;

  typedef enum logic {ST_IDLE, ST_FILL} ctrlState_t;

  // strobes from control to datapath, all mutually exclusive except accept
  typedef struct packed {
    logic accept;
    logic touch;
    logic swap;
    logic fill;
  } dpStrobe_t;
endpackage

// File: rtl/icache_ctrl.sv
module icache_ctrl
  import icache_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      reqValid,
  input  logic      mainHitNow,
  input  logic      vbHitNow,
  input  logic      fillValid,
  output logic      reqReady,
  output logic      fillReq,
  output dpStrobe_t strobe
);
  ctrlState_t state, stateNext;

  always_comb begin
    strobe = '0;
    stateNext = state;
    strobe.accept = (state == ST_IDLE) && reqValid;
    strobe.touch = strobe.accept && mainHitNow;
    strobe.swap = strobe.accept && !mainHitNow && vbHitNow;
    strobe.fill = (state == ST_FILL) && fillValid;
    if (strobe.accept && !mainHitNow && !vbHitNow) stateNext = ST_FILL;
    if (strobe.fill) stateNext = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else state <= stateNext;
  end

  assign reqReady = (state == ST_IDLE);
  assign fillReq = (state == ST_FILL);

  // R3: an outstanding line request is held until the next level answers
  a_r3_fill_held: assert property (@(posedge clk) disable iff (rst)
    fillReq && !fillValid |=> fillReq);
  // R9: a request raised during a pending fill never reaches the datapath
  a_r9_busy_ignored: assert property (@(posedge clk) disable iff (rst)
    $past(fillReq) && fillReq |-> !strobe.touch && !strobe.swap);
endmodule

// File: rtl/icache_datapath.sv
module icache_datapath
  import icache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS_PER_LINE = 2,
  parameter int NUM_SETS = 2,
  parameter int VB_ENTRIES = 2
) (
  input  logic                             clk,
  input  logic                             rst,
  input  dpStrobe_t                        strobe,
  input  logic [ADDR_W-1:0]                reqAddr,
  input  logic [DATA_W*WORDS_PER_LINE-1:0] fillData,
  output logic                             mainHitNow,
  output logic                             vbHitNow,
  output logic [ADDR_W-1:0]                fillAddr,
  output logic                             respValid,
  output logic [DATA_W-1:0]                respData,
  output logic                             respMainHit,
  output logic                             respVictimHit
);
  localparam int WORD_BITS = $clog2(WORDS_PER_LINE);
  localparam int SET_BITS = $clog2(NUM_SETS);
  localparam int LINE_ADDR_W = ADDR_W - WORD_BITS;
  localparam int TAG_W = LINE_ADDR_W - SET_BITS;
  localparam int LINE_W = DATA_W * WORDS_PER_LINE;
  localparam int PTR_W = $clog2(VB_ENTRIES);

  // main array
  logic [TAG_W-1:0]  mainTag  [NUM_SETS][WAYS];
  logic [LINE_W-1:0] mainData [NUM_SETS][WAYS];
  logic [WAYS-1:0]   mainValid [NUM_SETS];
  logic [NUM_SETS-1:0] lruWay;     // way to replace next, per set
  // victim buffer
  logic [LINE_ADDR_W-1:0] vbLine [VB_ENTRIES];
  logic [LINE_W-1:0]      vbData [VB_ENTRIES];
  logic [VB_ENTRIES-1:0]  vbValid;
  logic [PTR_W-1:0]       vbPtr;
  // pending miss
  logic [ADDR_W-1:0] pendAddr;

  function automatic logic pickWay(input logic [WAYS-1:0] v, input logic lru);
    if (!v[0]) return 1'b0;
    if (!v[1]) return 1'b1;
    return lru;
  endfunction

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(VB_ENTRIES - 1)) return '0;
    return p + 1'b1;
  endfunction

  function automatic logic [DATA_W-1:0] wordOf(input logic [LINE_W-1:0] ln,
                                               input logic [WORD_BITS-1:0] sel);
    return ln[sel*DATA_W +: DATA_W];
  endfunction

  // address split for lookup and for the pending fill
  logic [LINE_ADDR_W-1:0] lkLine, pendLine;
  logic [SET_BITS-1:0]    lkSet, pendSet;
  logic [TAG_W-1:0]       lkTag, pendTag;
  logic [WORD_BITS-1:0]   lkWord, pendWord;

  assign lkLine = reqAddr[ADDR_W-1:WORD_BITS];
  assign lkSet = lkLine[SET_BITS-1:0];
  assign lkTag = lkLine[LINE_ADDR_W-1:SET_BITS];
  assign lkWord = reqAddr[WORD_BITS-1:0];
  assign pendLine = pendAddr[ADDR_W-1:WORD_BITS];
  assign pendSet = pendLine[SET_BITS-1:0];
  assign pendTag = pendLine[LINE_ADDR_W-1:SET_BITS];
  assign pendWord = pendAddr[WORD_BITS-1:0];

  assign fillAddr = {pendLine, {WORD_BITS{1'b0}}};

  // main array lookup
  logic [WAYS-1:0] wayHit;
  logic            hitWay;
  always_comb begin
    for (int w = 0; w < WAYS; w++)
      wayHit[w] = mainValid[lkSet][w] && (mainTag[lkSet][w] == lkTag);
    hitWay = wayHit[1];
    mainHitNow = |wayHit;
  end

  // victim buffer lookup and free slot search
  logic [VB_ENTRIES-1:0] vbHitVec;
  logic [PTR_W-1:0]      vbHitIdx, freeSlot;
  always_comb begin
    vbHitIdx = '0;
    freeSlot = vbPtr;
    for (int k = VB_ENTRIES - 1; k >= 0; k--) begin
      vbHitVec[k] = vbValid[k] && (vbLine[k] == lkLine);
      if (vbHitVec[k]) vbHitIdx = PTR_W'(k);
      if (!vbValid[k]) freeSlot = PTR_W'(k);
    end
    vbHitNow = |vbHitVec;
  end

  // replacement choices and the lines they push out
  logic                   swapWay, fillWay, evValid;
  logic [LINE_ADDR_W-1:0] evLine, dsLine;
  logic [LINE_W-1:0]      evData, dsData;
  always_comb begin
    swapWay = pickWay(mainValid[lkSet], lruWay[lkSet]);
    fillWay = pickWay(mainValid[pendSet], lruWay[pendSet]);
    evValid = mainValid[pendSet][fillWay];
    evLine = {mainTag[pendSet][fillWay], pendSet};
    evData = mainData[pendSet][fillWay];
    dsLine = {mainTag[lkSet][swapWay], lkSet};
    dsData = mainData[lkSet][swapWay];
  end

  // valid bits, recency, pointer and response flags
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NUM_SETS; s++) mainValid[s] <= '0;
      lruWay <= '0;
      vbValid <= '0;
      vbPtr <= '0;
      respValid <= 1'b0;
      respMainHit <= 1'b0;
      respVictimHit <= 1'b0;
    end else begin
      respValid <= strobe.touch | strobe.swap | strobe.fill;
      respMainHit <= strobe.touch;
      respVictimHit <= strobe.swap;
      if (strobe.touch) lruWay[lkSet] <= ~hitWay;
      if (strobe.swap) begin
        mainValid[lkSet][swapWay] <= 1'b1;
        lruWay[lkSet] <= ~swapWay;
        vbValid[vbHitIdx] <= mainValid[lkSet][swapWay];
        vbPtr <= nextPtr(vbHitIdx);
      end
      if (strobe.fill) begin
        mainValid[pendSet][fillWay] <= 1'b1;
        lruWay[pendSet] <= ~fillWay;
        if (evValid) begin
          vbValid[freeSlot] <= 1'b1;
          vbPtr <= nextPtr(freeSlot);
        end
      end
    end
  end

  // tags, line data, pending address and response word
  always_ff @(posedge clk) begin
    if (strobe.accept) pendAddr <= reqAddr;
    if (strobe.touch) respData <= wordOf(mainData[lkSet][hitWay], lkWord);
    if (strobe.swap) begin
      respData <= wordOf(vbData[vbHitIdx], lkWord);
      mainTag[lkSet][swapWay] <= vbLine[vbHitIdx][LINE_ADDR_W-1:SET_BITS];
      mainData[lkSet][swapWay] <= vbData[vbHitIdx];
      vbLine[vbHitIdx] <= dsLine;
      vbData[vbHitIdx] <= dsData;
    end
    if (strobe.fill) begin
      respData <= wordOf(fillData, pendWord);
      mainTag[pendSet][fillWay] <= pendTag;
      mainData[pendSet][fillWay] <= fillData;
      if (evValid) begin
        vbLine[freeSlot] <= evLine;
        vbData[freeSlot] <= evData;
      end
    end
  end

  // R5: the way just hit becomes most recent
  a_r5_lru_on_hit: assert property (@(posedge clk) disable iff (rst)
    strobe.touch |=> lruWay[$past(lkSet)] != $past(hitWay));
  // R6: a valid line pushed out by a fill lands in the chosen slot
  a_r6_evict_kept: assert property (@(posedge clk) disable iff (rst)
    strobe.fill && evValid |=> vbValid[$past(freeSlot)] &&
                               vbLine[$past(freeSlot)] == $past(evLine));
  // R7: a swap leaves the requested line valid in the array
  a_r7_swap_installs: assert property (@(posedge clk) disable iff (rst)
    strobe.swap |=> mainValid[$past(lkSet)][$past(swapWay)]);

  // R8: no line lives in both structures
  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      for (genvar k = 0; k < VB_ENTRIES; k++) begin : g_slot
        a_r8_unique_line: assert property (@(posedge clk) disable iff (rst)
          !(mainValid[s][w] && vbValid[k] &&
            vbLine[k] == {mainTag[s][w], SET_BITS'(s)}));
      end
    end
  end
endmodule

// File: rtl/icache_victim.sv
module icache_victim
  import icache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS_PER_LINE = 2,
  parameter int NUM_SETS = 2,
  parameter int VB_ENTRIES = 2
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             reqValid,
  input  logic [ADDR_W-1:0]                reqAddr,
  output logic                             reqReady,
  output logic                             respValid,
  output logic [DATA_W-1:0]                respData,
  output logic                             respMainHit,
  output logic                             respVictimHit,
  output logic                             fillReq,
  output logic [ADDR_W-1:0]                fillAddr,
  input  logic                             fillValid,
  input  logic [DATA_W*WORDS_PER_LINE-1:0] fillData
);
  dpStrobe_t strobe;
  logic      mainHitNow, vbHitNow;

  icache_ctrl u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .mainHitNow(mainHitNow),
    .vbHitNow(vbHitNow), .fillValid(fillValid), .reqReady(reqReady),
    .fillReq(fillReq), .strobe(strobe)
  );

  icache_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS_PER_LINE(WORDS_PER_LINE),
    .NUM_SETS(NUM_SETS), .VB_ENTRIES(VB_ENTRIES)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .reqAddr(reqAddr),
    .fillData(fillData), .mainHitNow(mainHitNow), .vbHitNow(vbHitNow),
    .fillAddr(fillAddr), .respValid(respValid), .respData(respData),
    .respMainHit(respMainHit), .respVictimHit(respVictimHit)
  );

  // R4 R7: a response carries at most one hit kind
  a_r4_one_hit_kind: assert property (@(posedge clk) disable iff (rst)
    respValid |-> !(respMainHit && respVictimHit));
  // R3: a returned line always yields a miss response next cycle
  a_r3_fill_response: assert property (@(posedge clk) disable iff (rst)
    fillReq && fillValid |=> respValid && !respMainHit && !respVictimHit);
  // R10: no response appears without a preceding accept or fill
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !reqReady && !fillValid |=> !respValid);
endmodule

// File: tb/sim_icache_victim.sv
module sim_icache_victim;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqReady, respValid, respMainHit, respVictimHit, fillReq;
  logic [31:0] respData, fillAddr;
  logic        fillValid = 1'b0;
  logic [63:0] fillData = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  icache_victim u0 (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqReady(reqReady), .respValid(respValid), .respData(respData),
    .respMainHit(respMainHit), .respVictimHit(respVictimHit),
    .fillReq(fillReq), .fillAddr(fillAddr), .fillValid(fillValid),
    .fillData(fillData)
  );

  // reference state built from the requirements
  logic        mValid [2][2];
  logic [30:0] mLine  [2][2];
  logic        lru [2];
  logic        vValid [2];
  logic [30:0] vLine  [2];
  int          vPtr;

  function automatic logic [31:0] dataOf(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int pick(input int s);
    if (!mValid[s][0]) return 0;
    if (!mValid[s][1]) return 1;
    return int'(lru[s]);
  endfunction

  // kind: 0 array hit, 1 buffer hit, 2 miss
  task automatic predict(input logic [31:0] a, output int kind);
    logic [30:0] ln;
    int s, w, slot;
    ln = a[31:1];
    s = int'(ln[0]);
    kind = 2;
    for (int i = 0; i < 2; i++)
      if (mValid[s][i] && mLine[s][i] == ln) begin kind = 0; w = i; end
    if (kind == 0) begin
      lru[s] = (w == 0);
      return;
    end
    for (int k = 0; k < 2; k++)
      if (vValid[k] && vLine[k] == ln) begin kind = 1; slot = k; end
    w = pick(s);
    if (kind == 1) begin
      vLine[slot] = mLine[s][w];
      vValid[slot] = mValid[s][w];
      vPtr = (slot + 1) % 2;
    end else if (mValid[s][w]) begin
      slot = vPtr;
      for (int k = 1; k >= 0; k--) if (!vValid[k]) slot = k;
      vLine[slot] = mLine[s][w];
      vValid[slot] = 1'b1;
      vPtr = (slot + 1) % 2;
    end
    mLine[s][w] = ln;
    mValid[s][w] = 1'b1;
    lru[s] = (w == 0);
  endtask

  task automatic access(input logic [31:0] a, input bit stray);
    int kind;
    logic [31:0] base;
    base = {a[31:1], 1'b0};
    @(negedge clk);
    reqValid = 1'b1;
    reqAddr = a;
    predict(a, kind);
    @(negedge clk);
    reqValid = 1'b0;
    if (kind == 2) begin
      chk(fillReq && !respValid, "R3 miss raises fillReq (R5 R6 R8 state)",
          {30'd0, fillReq, respValid}, 32'h2);
      chk(fillAddr == base, "R2 fillAddr line aligned", fillAddr, base);
      if (stray) begin
        reqValid = 1'b1;
        reqAddr = a ^ 32'h40;
        chk(!reqReady, "R9 not ready during fill", {31'd0, reqReady}, 32'd0);
        @(negedge clk);
        reqValid = 1'b0;
        chk(fillReq && !respValid, "R3 fillReq held", {30'd0, fillReq, respValid}, 32'h2);
      end
      fillValid = 1'b1;
      fillData = {dataOf(base + 32'd1), dataOf(base)};
      @(negedge clk);
      fillValid = 1'b0;
      chk(respValid && !respMainHit && !respVictimHit, "R3 miss response flags",
          {29'd0, respValid, respMainHit, respVictimHit}, 32'h4);
      chk(respData == dataOf(a), "R3 R2 fill word select", respData, dataOf(a));
      if (stray) begin
        @(negedge clk);
        chk(!respValid && reqReady, "R9 stray request ignored",
            {30'd0, respValid, reqReady}, 32'h1);
      end
    end else if (kind == 0) begin
      chk(respValid && respMainHit && !respVictimHit, "R4 R5 array hit flags",
          {29'd0, respValid, respMainHit, respVictimHit}, 32'h6);
      chk(respData == dataOf(a), "R4 array hit data", respData, dataOf(a));
    end else begin
      chk(respValid && !respMainHit && respVictimHit, "R7 R6 R8 buffer hit flags",
          {29'd0, respValid, respMainHit, respVictimHit}, 32'h5);
      chk(respData == dataOf(a), "R7 buffer hit data", respData, dataOf(a));
    end
  endtask

  initial begin
    for (int s = 0; s < 2; s++) begin
      lru[s] = 1'b0;
      vValid[s] = 1'b0;
      vLine[s] = '0;
      for (int w = 0; w < 2; w++) begin mValid[s][w] = 1'b0; mLine[s][w] = '0; end
    end
    vPtr = 0;
    void'($urandom(32'd4321));
    repeat (3) @(negedge clk);
    chk(reqReady && !fillReq && !respValid, "R1 outputs in reset",
        {29'd0, reqReady, fillReq, respValid}, 32'h4);
    rst = 1'b0;
    @(negedge clk);
    chk(reqReady && !fillReq && !respValid, "R1 outputs after reset",
        {29'd0, reqReady, fillReq, respValid}, 32'h4);
    // directed: cold miss, word select, set fill, eviction and swap back
    access(32'h0, 1'b0);
    access(32'h1, 1'b0);
    access(32'h4, 1'b0);
    access(32'h8, 1'b0);
    access(32'h1, 1'b0);
    access(32'h4, 1'b0);
    access(32'hC, 1'b0);
    access(32'h3, 1'b0);
    access(32'h12, 1'b1);
    // R10: stray fill pulse while idle
    @(negedge clk);
    fillValid = 1'b1;
    fillData = 64'hDEAD_BEEF_0BAD_F00D;
    @(negedge clk);
    fillValid = 1'b0;
    chk(!respValid && reqReady && !fillReq, "R10 stray fill ignored",
        {29'd0, respValid, reqReady, fillReq}, 32'h2);
    access(32'h8, 1'b0);
    access(32'h12, 1'b0);
    // random traffic over twelve lines in both sets
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 4) == 0) @(negedge clk);
      access(32'($urandom_range(0, 23)), ($urandom_range(0, 19) == 0));
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule